// File: doc/BRIEF.md
# Time-of-Day Counter with Two-Stage Prescaler

This block derives a one-second timebase from a slow reference clock (nominally 32.768 kHz) and keeps the time of day in BCD. The reference clock feeds a programmable first divider. Its output pulses pace a second programmable divider. The current count of the second divider is available as a binary sub-second value. Each time the second divider wraps, the block emits a one-cycle strobe and advances a seconds/minutes/hours counter. Each field of that counter is held as a tens digit and a units digit.

The hours field runs in either 24-hour or 12-hour form, chosen by a format input. In 12-hour form a PM flag goes with the hours. Software sets the time through a load port. A load also restarts both divider stages, so the first second after a load lasts exactly one full period. Both divider reload values are inputs. The intended setting is a first-stage value of 127 and a second-stage value of 255. These give exactly one strobe per second from 32.768 kHz, with a sub-second step of 1/256 s. Date keeping is left to a neighbouring block, which can use the strobe and the hour rollover.

Top module: `tod_clock`

## Requirements
- R1: While `rst_ni` is low the block resets synchronously. After reset the time reads 00:00:00 when `fmt12_i`=0, or 12:00:00 with `pm_o`=0 when `fmt12_i`=1. `subsec_o` equals `sdiv_i` and `tick_o` is low.
- R2: The first stage counts down from `adiv_i` (A) to 0 and then reloads, so it pulses once every A+1 cycles. `subsec_o` counts down by one on each such pulse, from `sdiv_i` (S) to 0.
- R3: `tick_o` is a one-cycle pulse every (A+1)·(S+1) cycles. In the cycle where it is high, `subsec_o` already shows S again and the seconds have already advanced by one.
- R4: Each stage samples its reload value only when it wraps or restarts. A change to A or S in the middle of a count takes effect at that stage's next reload.
- R5: With A=127 and S=255, `tick_o` rises exactly 32768 cycles after the load edge.
- R6: Seconds and minutes count in BCD from 00 to 59. A units digit of 9 carries into the tens digit. 59 wraps to 00 and carries into the next field.
- R7: With `fmt12_i`=0, hours count 00 to 23 and 23 wraps to 00. `pm_o` reads 0 in the cycle after any cycle in which `fmt12_i` was 0, even if a load asked for PM.
- R8: With `fmt12_i`=1, hours run 12, 01, 02 … 11. The step from 12 to 01 leaves `pm_o` unchanged. The step from 11 to 12 inverts `pm_o`.
- R9: In the cycle after `load_i` is sampled high, the outputs show the loaded fields and `subsec_o`=S, and `tick_o` is low. This holds even if a wrap was due at that edge. The next tick comes exactly (A+1)·(S+1) cycles after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (32.768 kHz class) |
| rst_ni | input | 1 | Synchronous reset, active low |
| adiv_i | input | 7 | First-stage reload value A (divide by A+1) |
| sdiv_i | input | 15 | Second-stage reload value S (divide by S+1) |
| fmt12_i | input | 1 | 0 = 24-hour hours, 1 = 12-hour hours with PM flag |
| load_i | input | 1 | Load the time fields below and restart both dividers |
| ld_hr_t_i | input | 2 | Hours tens digit to load |
| ld_hr_u_i | input | 4 | Hours units digit to load |
| ld_mn_t_i | input | 3 | Minutes tens digit to load |
| ld_mn_u_i | input | 4 | Minutes units digit to load |
| ld_sc_t_i | input | 3 | Seconds tens digit to load |
| ld_sc_u_i | input | 4 | Seconds units digit to load |
| ld_pm_i | input | 1 | PM flag to load (12-hour mode only) |
| hr_t_o | output | 2 | Hours tens digit |
| hr_u_o | output | 4 | Hours units digit |
| mn_t_o | output | 3 | Minutes tens digit |
| mn_u_o | output | 4 | Minutes units digit |
| sc_t_o | output | 3 | Seconds tens digit |
| sc_u_o | output | 4 | Seconds units digit |
| pm_o | output | 1 | PM flag |
| subsec_o | output | 15 | Second-stage count, binary, counting down |
| tick_o | output | 1 | One-cycle strobe, once per second |

## Verification
A fault in the first stage shows within A+1 cycles, because `subsec_o` then steps at the wrong spacing. A fault in the second stage shows within one second, as a misplaced or missing `tick_o` or a wrong reload value. Carry faults in the BCD fields stay hidden until the counter crosses the affected boundary. For that reason the bench loads times just before units, tens, minute, hour, noon and midnight boundaries, and runs a divide-by-one setting so that every cycle is a second. The small divider settings are swept exhaustively so that each cycle's sub-second value can be compared against a formula.

// File: rtl/tod_pkg.sv
package tod_pkg;

    // Reload values that give a 1 Hz tick from a 32.768 kHz reference
    localparam int unsigned ADIV_NOMINAL = 127;
    localparam int unsigned SDIV_NOMINAL = 255;

    typedef struct packed {
        logic       pm;
        logic [1:0] hr_t;
        logic [3:0] hr_u;
        logic [2:0] mn_t;
        logic [3:0] mn_u;
        logic [2:0] sc_t;
        logic [3:0] sc_u;
    } tod_time_t;

endpackage

// File: rtl/tod_divstage.sv
module tod_divstage #(
    parameter int W = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         restart_i,
    input  logic         en_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap_o = en_i && (cnt_q == '0) && !restart_i;
        cnt_d  = cnt_q;
        if (restart_i || wrap_o) begin
            cnt_d = reload_i;
        end else if (en_i) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= reload_i;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tod_bcd_time.sv
module tod_bcd_time
    import tod_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      fmt12_i,
    input  logic      advance_i,
    input  logic      load_i,
    input  tod_time_t load_val_i,
    output tod_time_t time_o
);

    tod_time_t time_d, time_q, rst_val;
    logic sec_wrap, min_wrap, hr24_last, hr12_last, hr_eleven;

    always_comb begin
        rst_val      = '0;
        rst_val.hr_t = fmt12_i ? 2'd1 : 2'd0;
        rst_val.hr_u = fmt12_i ? 4'd2 : 4'd0;
    end

    always_comb begin
        time_d    = time_q;
        sec_wrap  = (time_q.sc_t == 3'd5) && (time_q.sc_u == 4'd9);
        min_wrap  = (time_q.mn_t == 3'd5) && (time_q.mn_u == 4'd9);
        hr24_last = (time_q.hr_t == 2'd2) && (time_q.hr_u == 4'd3);
        hr12_last = (time_q.hr_t == 2'd1) && (time_q.hr_u == 4'd2);
        hr_eleven = (time_q.hr_t == 2'd1) && (time_q.hr_u == 4'd1);

        if (advance_i) begin
            // seconds
            if (sec_wrap) begin
                time_d.sc_t = 3'd0;
                time_d.sc_u = 4'd0;
            end else if (time_q.sc_u == 4'd9) begin
                time_d.sc_u = 4'd0;
                time_d.sc_t = time_q.sc_t + 3'd1;
            end else begin
                time_d.sc_u = time_q.sc_u + 4'd1;
            end
            // minutes
            if (sec_wrap) begin
                if (min_wrap) begin
                    time_d.mn_t = 3'd0;
                    time_d.mn_u = 4'd0;
                end else if (time_q.mn_u == 4'd9) begin
                    time_d.mn_u = 4'd0;
                    time_d.mn_t = time_q.mn_t + 3'd1;
                end else begin
                    time_d.mn_u = time_q.mn_u + 4'd1;
                end
            end
            // hours
            if (sec_wrap && min_wrap) begin
                if (fmt12_i && hr12_last) begin
                    time_d.hr_t = 2'd0;
                    time_d.hr_u = 4'd1;
                end else if (!fmt12_i && hr24_last) begin
                    time_d.hr_t = 2'd0;
                    time_d.hr_u = 4'd0;
                end else begin
                    if (fmt12_i && hr_eleven) begin
                        time_d.pm = ~time_q.pm;
                    end
                    if (time_q.hr_u == 4'd9) begin
                        time_d.hr_u = 4'd0;
                        time_d.hr_t = time_q.hr_t + 2'd1;
                    end else begin
                        time_d.hr_u = time_q.hr_u + 4'd1;
                    end
                end
            end
        end

        if (load_i) begin
            time_d = load_val_i;
        end
        if (!fmt12_i) begin
            time_d.pm = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            time_q <= rst_val;
        end else begin
            time_q <= time_d;
        end
    end

    assign time_o = time_q;

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int ADIV_W = 7,
    parameter int SDIV_W = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADIV_W-1:0] adiv_i,
    input  logic [SDIV_W-1:0] sdiv_i,
    input  logic              fmt12_i,
    input  logic              load_i,
    input  logic [1:0]        ld_hr_t_i,
    input  logic [3:0]        ld_hr_u_i,
    input  logic [2:0]        ld_mn_t_i,
    input  logic [3:0]        ld_mn_u_i,
    input  logic [2:0]        ld_sc_t_i,
    input  logic [3:0]        ld_sc_u_i,
    input  logic              ld_pm_i,
    output logic [1:0]        hr_t_o,
    output logic [3:0]        hr_u_o,
    output logic [2:0]        mn_t_o,
    output logic [3:0]        mn_u_o,
    output logic [2:0]        sc_t_o,
    output logic [3:0]        sc_u_o,
    output logic              pm_o,
    output logic [SDIV_W-1:0] subsec_o
,
    output logic              tick_o
);

    localparam int SUB_W = SDIV_W;

    typedef struct packed {
        logic tick;
    } top_state_t;

    logic              a_wrap, s_wrap;
    logic [ADIV_W-1:0] a_cnt;
    logic [SUB_W-1:0]  s_cnt;
    tod_time_t         ld_val, time_cur;
    top_state_t        st_d, st_q;

    tod_divstage #(.W(ADIV_W)) u_async (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (load_i),
        .en_i      (1'b1),
        .reload_i  (adiv_i),
        .cnt_o     (a_cnt),
        .wrap_o    (a_wrap)
    );

    tod_divstage #(.W(SUB_W)) u_sync (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (load_i),
        .en_i      (a_wrap),
        .reload_i  (sdiv_i),
        .cnt_o     (s_cnt),
        .wrap_o    (s_wrap)
    );

    always_comb begin
        ld_val.pm   = ld_pm_i;
        ld_val.hr_t = ld_hr_t_i;
        ld_val.hr_u = ld_hr_u_i;
        ld_val.mn_t = ld_mn_t_i;
        ld_val.mn_u = ld_mn_u_i;
        ld_val.sc_t = ld_sc_t_i;
        ld_val.sc_u = ld_sc_u_i;
    end

    tod_bcd_time u_time (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fmt12_i    (fmt12_i),
        .advance_i  (s_wrap),
        .load_i     (load_i),
        .load_val_i (ld_val),
        .time_o     (time_cur)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tick = s_wrap;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hr_t_o   = time_cur.hr_t;
    assign hr_u_o   = time_cur.hr_u;
    assign mn_t_o   = time_cur.mn_t;
    assign mn_u_o   = time_cur.mn_u;
    assign sc_t_o   = time_cur.sc_t;
    assign sc_u_o   = time_cur.sc_u;
    assign pm_o     = time_cur.pm;
    assign subsec_o = s_cnt;
    assign tick_o   = st_q.tick;

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
    parameter int ADIV_W = 7,
    parameter int SDIV_W = 15
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              load_i,
    input logic              fmt12_i,
    input logic [SDIV_W-1:0] sdiv_i,
    input logic [3:0]        ld_sc_u_i,
    input logic [3:0]        sc_u_o,
    input logic [3:0]        mn_u_o,
    input logic [3:0]        hr_u_o,
    input logic              pm_o,
    input logic [SDIV_W-1:0] subsec_o,
    input logic              tick_o,
    input logic [ADIV_W-1:0] a_cnt
);

    AST_TICK_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (subsec_o == $past(sdiv_i))); // R3

    AST_TICK_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (sc_u_o != $past(sc_u_o))); // R6

    AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(load_i) && !tick_o)
            |-> ($stable(sc_u_o) && $stable(mn_u_o) && $stable(hr_u_o))); // R3

    AST_LOAD_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(load_i))
            |-> (!tick_o && subsec_o == $past(sdiv_i) && sc_u_o == $past(ld_sc_u_i))); // R9

    AST_PM_24H: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(fmt12_i) |-> !pm_o); // R7

    AST_SUBSEC_PACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(load_i) && (subsec_o != $past(subsec_o)))
            |-> ($past(a_cnt) == '0)); // R2

    AST_SUBSEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(load_i) && !tick_o && (subsec_o != $past(subsec_o)))
            |-> (subsec_o == $past(subsec_o) - 1'b1)); // R2

endmodule

bind tod_clock tod_clock_chk #(.ADIV_W(ADIV_W), .SDIV_W(SDIV_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .fmt12_i   (fmt12_i),
    .sdiv_i    (sdiv_i),
    .ld_sc_u_i (ld_sc_u_i),
    .sc_u_o    (sc_u_o),
    .mn_u_o    (mn_u_o),
    .hr_u_o    (hr_u_o),
    .pm_o      (pm_o),
    .subsec_o  (subsec_o),
    .tick_o    (tick_o),
    .a_cnt     (a_cnt)
);

// File: tb/tod_clock_tb_top.sv
module tod_clock_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  adiv = 7'd0;
    logic [14:0] sdiv = 15'd0;
    logic        fmt12 = 1'b0;
    logic        load = 1'b0;
    logic [1:0]  l_hr_t = '0;
    logic [3:0]  l_hr_u = '0;
    logic [2:0]  l_mn_t = '0;
    logic [3:0]  l_mn_u = '0;
    logic [2:0]  l_sc_t = '0;
    logic [3:0]  l_sc_u = '0;
    logic        l_pm = 1'b0;
    logic [1:0]  hr_t;
    logic [3:0]  hr_u;
    logic [2:0]  mn_t;
    logic [3:0]  mn_u;
    logic [2:0]  sc_t;
    logic [3:0]  sc_u;
    logic        pm;
    logic [14:0] subsec;
    logic        tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tod_clock dut_i (
        .clk_i(clk), .rst_ni(rst_n), .adiv_i(adiv), .sdiv_i(sdiv),
        .fmt12_i(fmt12), .load_i(load),
        .ld_hr_t_i(l_hr_t), .ld_hr_u_i(l_hr_u), .ld_mn_t_i(l_mn_t),
        .ld_mn_u_i(l_mn_u), .ld_sc_t_i(l_sc_t), .ld_sc_u_i(l_sc_u),
        .ld_pm_i(l_pm),
        .hr_t_o(hr_t), .hr_u_o(hr_u), .mn_t_o(mn_t), .mn_u_o(mn_u),
        .sc_t_o(sc_t), .sc_u_o(sc_u), .pm_o(pm),
        .subsec_o(subsec), .tick_o(tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // decimal image pm*1e6 + hh*1e4 + mm*100 + ss of the outputs
    function automatic longint shown();
        return longint'(pm) * 1000000
             + longint'(hr_t * 10 + hr_u) * 10000
             + longint'(mn_t * 10 + mn_u) * 100
             + longint'(sc_t * 10 + sc_u);
    endfunction

    // same image computed from seconds-of-day
    function automatic longint model(input int t_in, input bit f12);
        int t, h24, h, m, s;
        bit p;
        t   = t_in % 86400;
        h24 = t / 3600;
        m   = (t / 60) % 60;
        s   = t % 60;
        if (f12) begin
            h = (h24 % 12 == 0) ? 12 : h24 % 12;
            p = (h24 >= 12);
        end else begin
            h = h24;
            p = 1'b0;
        end
        return longint'(p) * 1000000 + longint'(h) * 10000 + longint'(m) * 100 + longint'(s);
    endfunction

    // drive load at the current negedge; returns at the negedge after the load edge
    task automatic do_load(input int t, input bit f12, input bit force_pm);
        int h24, h;
        h24 = (t % 86400) / 3600;
        h   = f12 ? ((h24 % 12 == 0) ? 12 : h24 % 12) : h24;
        fmt12  = f12;
        l_hr_t = 2'(h / 10);
        l_hr_u = 4'(h % 10);
        l_mn_t = 3'(((t / 60) % 60) / 10);
        l_mn_u = 4'(((t / 60) % 60) % 10);
        l_sc_t = 3'((t % 60) / 10);
        l_sc_u = 4'((t % 60) % 10);
        l_pm   = force_pm | (f12 && h24 >= 12);
        load   = 1'b1;
        @(negedge clk);
        load   = 1'b0;
    endtask

    task automatic run_window(input int a, input int s, input int t0, input int ncyc,
                              input bit f12, input bit force_pm,
                              input string rq_tick, input string rq_time);
        int n;
        @(negedge clk);
        adiv = 7'(a);
        sdiv = 15'(s);
        do_load(t0, f12, force_pm);
        n = (a + 1) * (s + 1);
        for (int c = 0; c <= ncyc; c++) begin
            if (c > 0) @(negedge clk);
            chk(subsec == 15'(s - (c % n) / (a + 1)), "R2", "subsec", subsec,
                s - (c % n) / (a + 1));
            chk(tick == (c > 0 && c % n == 0), rq_tick, "tick", tick,
                (c > 0 && c % n == 0));
            chk(shown() == model(t0 + c / n, f12), rq_time, "time", shown(),
                model(t0 + c / n, f12));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int t1;
        // R1: reset state, 24-hour
        adiv = 7'd2; sdiv = 15'd5; fmt12 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(shown() == 0, "R1", "reset time 24h", shown(), 0);
        chk(subsec == 15'd5, "R1", "reset subsec", subsec, 5);
        chk(tick == 1'b0, "R1", "reset tick", tick, 0);

        // R1: reset state, 12-hour
        rst_n = 1'b0; fmt12 = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(shown() == model(0, 1'b1), "R1", "reset time 12h", shown(), model(0, 1'b1));

        // R2/R3: exhaustive small-divider sweep, crossing 03:59:59 -> 04:00:00 (R6)
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 4; s++) begin
                run_window(a, s, 3 * 3600 + 59 * 60 + 58, 2 * (a + 1) * (s + 1) + 1,
                           1'b0, 1'b0, "R3", "R6");
            end
        end

        // R5: nominal dividers
        run_window(127, 255, 12 * 3600 + 34 * 60 + 56, 32769, 1'b0, 1'b0, "R5", "R5");

        // R7: 24-hour run over midnight, with a PM request on load
        run_window(0, 0, 22 * 3600 + 59 * 60 + 30, 3700, 1'b0, 1'b1, "R3", "R7");

        // R8: 12-hour boundaries
        run_window(0, 0, 11 * 3600 + 59 * 60 + 50, 30, 1'b1, 1'b0, "R3", "R8");
        run_window(0, 0, 12 * 3600 + 59 * 60 + 50, 30, 1'b1, 1'b0, "R3", "R8");
        run_window(0, 0, 23 * 3600 + 59 * 60 + 50, 30, 1'b1, 1'b0, "R3", "R8");
        run_window(0, 0, 59 * 60 + 50, 30, 1'b1, 1'b0, "R3", "R8");
        run_window(0, 0, 9 * 3600 + 59 * 60 + 40, 40, 1'b1, 1'b0, "R3", "R8");

        // R4: S change mid-count takes effect at next reload
        @(negedge clk);
        adiv = 7'd0; sdiv = 15'd3;
        do_load(100, 1'b0, 1'b0);
        @(negedge clk); sdiv = 15'd1;           // c=1
        chk(subsec == 15'd2, "R4", "subsec c1", subsec, 2);
        @(negedge clk);                          // c=2
        @(negedge clk);                          // c=3
        chk(subsec == 15'd0 && tick == 1'b0, "R4", "subsec c3", subsec, 0);
        @(negedge clk);                          // c=4
        chk(tick == 1'b1 && subsec == 15'd1, "R4", "new S reload", subsec, 1);
        @(negedge clk); @(negedge clk);          // c=6
        chk(tick == 1'b1, "R4", "short period tick", tick, 1);

        // R4: A change mid-count
        @(negedge clk);
        adiv = 7'd3; sdiv = 15'd1;
        do_load(200, 1'b0, 1'b0);
        @(negedge clk); adiv = 7'd0;             // c=1
        @(negedge clk); @(negedge clk); @(negedge clk);  // c=4
        chk(subsec == 15'd0 && tick == 1'b0, "R4", "A old period", subsec, 0);
        @(negedge clk);                          // c=5
        chk(tick == 1'b1, "R4", "A new period tick c5", tick, 1);
        @(negedge clk); @(negedge clk);          // c=7
        chk(tick == 1'b1, "R4", "A new period tick c7", tick, 1);

        // R9: load in the cycle a wrap is due suppresses that tick
        @(negedge clk);
        adiv = 7'd0; sdiv = 15'd3;
        do_load(100, 1'b0, 1'b0);
        repeat (3) @(negedge clk);               // c=3: wrap due at next edge
        t1 = 500;
        do_load(t1, 1'b0, 1'b0);
        chk(tick == 1'b0, "R9", "tick after load", tick, 0);
        chk(shown() == model(t1, 1'b0), "R9", "loaded time", shown(), model(t1, 1'b0));
        chk(subsec == 15'd3, "R9", "subsec after load", subsec, 3);
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R9", "no early tick", tick, 0);
        @(negedge clk);
        chk(tick == 1'b1 && shown() == model(t1 + 1, 1'b0), "R9", "first tick after load",
            shown(), model(t1 + 1, 1'b0));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule